// File: doc/BRIEF.md
# Gated Time Pulse Accumulator

This block is a 16-bit pulse accumulator with two ways of counting. In gated-time mode it counts ticks of a divide-by-64 time base, but only while an external gate input stays at its chosen active level. The count then measures how long the gate was active, in units of 64 timer cycles. In event mode it counts each transition of the input into its active level. The time base comes from a 6-bit prescaler that runs only while the timer is enabled. It produces a one-cycle enable pulse, not a derived clock.

The gate input passes through a two-flop synchroniser before any level or edge decision is made. The accumulator can be loaded from a parallel port and read at any time. Two sticky flags record events. The input flag sets on the trailing edge of the active level in gated mode, and on the counted edge in event mode. The overflow flag sets when the count wraps. Each flag has a clear strobe and an interrupt enable, and each drives an active-high interrupt request.

Top module: `gated_pulse_accum`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the count is 0x0000, and both flags and both interrupt requests are 0.
- R2: With gate_mode=1 (gated time) and acc_en=1, the count rises by one on every 64th clock cycle in which timer_en is high, counted from when timer_en was last raised, if the synchronised gate level is active in that cycle.
- R3: gate_high=1 makes a high level on gate_in the active level. gate_high=0 makes a low level the active level.
- R4: A change on gate_in reaches level and edge detection after exactly two clock edges. The flag it causes is visible after the third edge.
- R5: While timer_en is 0 the prescaler is held at its start and the count does not advance in gated mode.
- R6: In gated mode, a synchronised change from active to inactive sets edge_flag. A change from inactive to active does not.
- R7: With gate_mode=0 (event mode) and acc_en=1, each synchronised change from inactive to active raises the count by one and sets edge_flag, whatever timer_en is.
- R8: load_stb=1 writes load_val into the count at the next edge. In that cycle the load takes priority over any increment.
- R9: An increment from 0xFFFF gives 0x0000 and sets ovf_flag.
- R10: clr_edge / clr_ovf clear their flag at the next edge. When a set event and a clear occur in the same cycle, the flag ends up set.
- R11: edge_irq = edge_flag AND edge_ie, and ovf_irq = ovf_flag AND ovf_ie.
- R12: With acc_en=0 the count neither increments nor sets a flag, and existing flags keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_en | input | 1 | Runs the divide-by-64 prescaler |
| acc_en | input | 1 | Enables the accumulator |
| gate_mode | input | 1 | 1 = gated time, 0 = event counting |
| gate_high | input | 1 | 1 = high level active, 0 = low level active |
| gate_in | input | 1 | Asynchronous gate / event input |
| load_stb | input | 1 | Loads load_val into the count |
| load_val | input | 16 | Value to load |
| clr_edge | input | 1 | Clears edge_flag |
| clr_ovf | input | 1 | Clears ovf_flag |
| edge_ie | input | 1 | Interrupt enable for edge_flag |
| ovf_ie | input | 1 | Interrupt enable for ovf_flag |
| count | output | 16 | Accumulator value |
| edge_flag | output | 1 | Input edge flag |
| ovf_flag | output | 1 | Overflow flag |
| edge_irq | output | 1 | Input edge interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench targets the following corner cases:
- The count advances only in a gated cycle and only on the 64th cycle of the time base. A prescaler that kept running while the timer was off would give an off-by-some count once the timer is enabled again.
- The flag must stay at zero two edges after a gate change and appear on the third edge. A design with the wrong synchroniser depth fails that check.
- The count is loaded just below 0xFFFF so that the wrap and the overflow flag are tested. A clear strobe is placed in the same cycle as an edge, and the flag must then stay set.
- Random traffic switches polarity, mode and enables while a cycle-level reference model checks every output. A design that took the leading edge for the trailing one, or that missed a polarity change, fails those checks.

// File: rtl/gpa_pkg.sv
// Package gpa_pkg: shared mode encoding and level helper for the gated
// pulse accumulator. Assumes one-bit mode and polarity controls.
package gpa_pkg;

    typedef enum logic {
        ACC_EVENT = 1'b0,
        ACC_GATED = 1'b1
    } acc_mode_e;

    // True when a synchronised level equals the selected active level.
    function automatic logic level_active(input logic level, input logic high_active);
        return (level == high_active);
    endfunction

endpackage

// File: rtl/gpa_sync.sv
// Module gpa_sync: multi-flop synchroniser for an asynchronous input plus
// one further flop for edge detection. Assumes STAGES >= 2. Reset clears
// every stage, so the input should match that value when reset is released.
module gpa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic level_d
);

    logic [STAGES-1:0] chain;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];

    // R4: the last stage carries the previous content of the stage before it
    a_r4_stage: assert property (@(posedge clk) disable iff (!rst_n)
        chain[STAGES-1] == $past(chain[STAGES-2]));

    // R4: the edge flop lags the output level by one cycle
    a_r4_edge_lag: assert property (@(posedge clk) disable iff (!rst_n)
        level_d == $past(level));

endmodule

// File: rtl/gpa_prescale.sv
// Module gpa_prescale: free-running DIV_BITS-bit counter that emits a
// one-cycle tick every 2**DIV_BITS enabled cycles. While run is low the
// counter is held at zero, so no tick is produced.
module gpa_prescale #(
    parameter int DIV_BITS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam logic [DIV_BITS-1:0] LAST = '1;

    logic [DIV_BITS-1:0] div_cnt;

    // Advance while running, otherwise return to the start value.
    always_ff @(posedge clk) begin
        if (!rst_n)   div_cnt <= '0;
        else if (run) div_cnt <= div_cnt + 1'b1;
        else          div_cnt <= '0;
    end

    // Tick in the last cycle of each period.
    assign tick = run && (div_cnt == LAST);

    // R5: a stopped prescaler sits at its start value
    a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_cnt == '0));

    // R2: ticks are never back to back
    a_r2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/gpa_accum.sv
// Module gpa_accum: WIDTH-bit loadable up-counter. A load takes priority
// over an increment. Wraps from all ones to zero and reports the wrap
// combinationally in the same cycle as the increment that causes it.
module gpa_accum #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] value,
    output logic             wrap
);

    localparam logic [WIDTH-1:0] TOP = '1;

    // Load, increment or hold the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= load_val;
        else if (inc)  value <= value + 1'b1;
    end

    // Flag the increment that rolls the count over.
    assign wrap = inc && !load && (value == TOP);

    // R8: a load shows the loaded value one edge later
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (value == $past(load_val)));

    // R9: an increment from the top value yields zero
    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && value == TOP) |=> (value == '0));

    // R12: without an increment or a load the count holds
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(value));

endmodule

// File: rtl/gpa_flag.sv
// Module gpa_flag: sticky event flag with a write-one clear strobe and an
// interrupt enable. A set in the same cycle as a clear leaves the flag set.
module gpa_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);

    // Set wins over clear; otherwise keep the state.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // Request only while enabled.
    assign irq = flag && ie;

    // R10: a set event always leaves the flag set
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    // R10: a clear with no set clears the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);

    // R12: with no set the flag never rises
    a_r12_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !set |=> !$rose(flag));

endmodule

// File: rtl/gated_pulse_accum.sv
// Module gated_pulse_accum: pulse accumulator with a gated-time mode and an
// event-counting mode. Gate input is asynchronous; it is synchronised here.
// The time base is a one-cycle tick from an internal prescaler that runs
// only while timer_en is high. All state uses synchronous active-low reset.
module gated_pulse_accum #(
    parameter int CNT_W       = 16,
    parameter int DIV_BITS    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timer_en,
    input  logic             acc_en,
    input  logic             gate_mode,
    input  logic             gate_high,
    input  logic             gate_in,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr_edge,
    input  logic             clr_ovf,
    input  logic             edge_ie,
    input  logic             ovf_ie,
    output logic [CNT_W-1:0] count,
    output logic             edge_flag,
    output logic             ovf_flag,
    output logic             edge_irq,
    output logic             ovf_irq
);

    import gpa_pkg::*;

    acc_mode_e mode;
    logic      lvl, lvl_d;
    logic      act_now, act_prev;
    logic      lead, trail;
    logic      tick;
    logic      inc, wrap, edge_set;

    assign mode = acc_mode_e'(gate_mode);

    gpa_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(gate_in),
        .level(lvl), .level_d(lvl_d)
    );

    gpa_prescale #(.DIV_BITS(DIV_BITS)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(timer_en), .tick(tick)
    );

    // Classify the synchronised level against the selected polarity.
    always_comb begin
        act_now  = level_active(lvl, gate_high);
        act_prev = level_active(lvl_d, gate_high);
        lead     = act_now && !act_prev;
        trail    = act_prev && !act_now;
    end

    // Choose the increment source and the edge-flag event for the mode.
    always_comb begin
        unique case (mode)
            ACC_GATED: begin
                inc      = acc_en && tick && act_now;
                edge_set = acc_en && trail;
            end
            default: begin
                inc      = acc_en && lead;
                edge_set = acc_en && lead;
            end
        endcase
    end

    gpa_accum #(.WIDTH(CNT_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .inc(inc), .load(load_stb),
        .load_val(load_val), .value(count), .wrap(wrap)
    );

    gpa_flag u_edge_flag (
        .clk(clk), .rst_n(rst_n), .set(edge_set), .clr(clr_edge),
        .ie(edge_ie), .flag(edge_flag), .irq(edge_irq)
    );

    gpa_flag u_ovf_flag (
        .clk(clk), .rst_n(rst_n), .set(wrap), .clr(clr_ovf),
        .ie(ovf_ie), .flag(ovf_flag), .irq(ovf_irq)
    );

    // R7: in event mode a counted edge raises the count by one
    a_r7_event_count: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ACC_EVENT && acc_en && lead && !load_stb)
        |=> (count == $past(count) + 1'b1));

    // R5: gated counting needs a running timer
    a_r5_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ACC_GATED && !timer_en && !load_stb) |=> $stable(count));

    // R6: in gated mode a leading edge alone does not set the flag
    a_r6_not_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ACC_GATED && lead && !edge_flag) |=> !edge_flag);

endmodule

// File: tb/gated_pulse_accum_test.sv
module gated_pulse_accum_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        timer_en = 0, acc_en = 0, gate_mode = 0, gate_high = 0, gate_in = 0;
    logic        load_stb = 0, clr_edge = 0, clr_ovf = 0, edge_ie = 0, ovf_ie = 0;
    logic [15:0] load_val = '0;
    logic [15:0] count;
    logic        edge_flag, ovf_flag, edge_irq, ovf_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    gated_pulse_accum uut (
        .clk(clk), .rst_n(rst_n), .timer_en(timer_en), .acc_en(acc_en),
        .gate_mode(gate_mode), .gate_high(gate_high), .gate_in(gate_in),
        .load_stb(load_stb), .load_val(load_val), .clr_edge(clr_edge),
        .clr_ovf(clr_ovf), .edge_ie(edge_ie), .ovf_ie(ovf_ie),
        .count(count), .edge_flag(edge_flag), .ovf_flag(ovf_flag),
        .edge_irq(edge_irq), .ovf_irq(ovf_irq)
    );

    // Reference model, built from the requirements, updated at each edge.
    logic       m_s1 = 0, m_s2 = 0, m_s3 = 0;
    int         m_pre = 0;
    logic [15:0] m_cnt = 0;
    logic       m_ef = 0, m_of = 0;

    function automatic bit is_act(input logic lvl, input logic hi);
        return lvl == hi;
    endfunction

    always @(posedge clk) begin
        bit an, ap, tk, inc, eset, oset;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0; m_cnt = 0; m_ef = 0; m_of = 0;
        end else begin
            an = is_act(m_s2, gate_high);
            ap = is_act(m_s3, gate_high);
            tk = timer_en && (m_pre == 63);
            if (gate_mode) begin
                inc  = acc_en && tk && an;
                eset = acc_en && ap && !an;
            end else begin
                inc  = acc_en && an && !ap;
                eset = inc;
            end
            oset = inc && !load_stb && (m_cnt == 16'hFFFF);
            if (load_stb) m_cnt = load_val;
            else if (inc) m_cnt = m_cnt + 16'd1;
            if (eset) m_ef = 1; else if (clr_edge) m_ef = 0;
            if (oset) m_of = 1; else if (clr_ovf) m_of = 0;
            m_pre = timer_en ? (m_pre + 1) % 64 : 0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = gate_in;
        end
    end

    task automatic expect_val(input string req, input string what,
                              input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // Advance n cycles; compare every output with the model at each negedge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) begin
                expect_val("R2", "count", {16'h0, count}, {16'h0, m_cnt});
                expect_val("R6", "edge_flag", {31'h0, edge_flag}, {31'h0, m_ef});
                expect_val("R9", "ovf_flag", {31'h0, ovf_flag}, {31'h0, m_of});
                expect_val("R11", "edge_irq", {31'h0, edge_irq}, {31'h0, m_ef & edge_ie});
                expect_val("R11", "ovf_irq", {31'h0, ovf_irq}, {31'h0, m_of & ovf_ie});
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED);
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        expect_val("R1", "count", {16'h0, count}, 32'h0);
        expect_val("R1", "flags", {30'h0, edge_flag, ovf_flag}, 32'h0);
        expect_val("R1", "irqs", {30'h0, edge_irq, ovf_irq}, 32'h0);

        // R5: gated, low-active gate held active, timer off -> no counting
        gate_mode = 1; gate_high = 0; gate_in = 0; acc_en = 1;
        step(300);
        expect_val("R5", "count timer off", {16'h0, count}, 32'h0);

        // R2: 320 enabled cycles with active gate -> 5 ticks counted (R3 low active)
        timer_en = 1;
        step(320);
        timer_en = 0;
        step(3);
        expect_val("R2", "count after 320 cycles", {16'h0, count}, 32'd5);
        expect_val("R3", "low level counted", {31'h0, count != 0}, 32'd1);

        // R4/R6: trailing edge; flag still clear after two edges, set after three
        gate_in = 1;
        step(2);
        expect_val("R4", "flag after two edges", {31'h0, edge_flag}, 32'd0);
        step(1);
        expect_val("R6", "flag after trailing edge", {31'h0, edge_flag}, 32'd1);
        expect_val("R11", "edge_irq disabled", {31'h0, edge_irq}, 32'd0);
        edge_ie = 1;
        step(1);
        expect_val("R11", "edge_irq enabled", {31'h0, edge_irq}, 32'd1);

        // R10: clear the edge flag
        clr_edge = 1; step(1); clr_edge = 0;
        expect_val("R10", "edge flag cleared", {31'h0, edge_flag}, 32'd0);

        // R8: load near the top
        load_stb = 1; load_val = 16'hFFFE; step(1); load_stb = 0;
        expect_val("R8", "loaded", {16'h0, count}, 32'hFFFE);

        // R9: wrap after two ticks with gate active again
        gate_in = 0; step(3);
        expect_val("R6", "leading edge sets nothing", {31'h0, edge_flag}, 32'd0);
        timer_en = 1; step(128); timer_en = 0;
        expect_val("R9", "wrapped count", {16'h0, count}, 32'h0);
        expect_val("R9", "overflow flag", {31'h0, ovf_flag}, 32'd1);
        ovf_ie = 1; step(1);
        expect_val("R11", "ovf_irq", {31'h0, ovf_irq}, 32'd1);
        clr_ovf = 1; step(1); clr_ovf = 0;
        expect_val("R10", "ovf cleared", {31'h0, ovf_flag}, 32'd0);

        // R7: event mode, high active; each rise counts
        gate_mode = 0; gate_high = 1; step(3);
        gate_in = 1; step(3);
        expect_val("R7", "first event", {16'h0, count}, 32'd1);
        expect_val("R7", "event flag", {31'h0, edge_flag}, 32'd1);
        gate_in = 0; step(3);
        gate_in = 1; step(2);
        // R10: clear in the same cycle as a set event -> stays set
        clr_edge = 1; step(1); clr_edge = 0;
        expect_val("R10", "set wins over clear", {31'h0, edge_flag}, 32'd1);
        expect_val("R7", "second event", {16'h0, count}, 32'd2);

        // R12: accumulator disabled -> events ignored, flag kept
        acc_en = 0;
        gate_in = 0; step(3); gate_in = 1; step(3);
        expect_val("R12", "count held", {16'h0, count}, 32'd2);
        expect_val("R12", "flag kept", {31'h0, edge_flag}, 32'd1);
        acc_en = 1;

        // R3: gated mode with a high-active gate that is high
        gate_mode = 1; timer_en = 1; step(64); timer_en = 0;
        expect_val("R3", "high level counted", {16'h0, count}, 32'd3);

        // Constrained random phase checked against the model each cycle.
        for (int cyc = 0; cyc < 20000; cyc++) begin
            int r;
            r = int'($urandom % 1000);
            if (cyc % 1500 == 0) begin
                gate_mode = $urandom % 2;
                gate_high = $urandom % 2;
                edge_ie   = $urandom % 2;
                ovf_ie    = $urandom % 2;
                timer_en  = ($urandom % 4) != 0;
                acc_en    = ($urandom % 8) != 0;
            end
            if (gate_mode) gate_in = (r < 12) ? ~gate_in : gate_in;
            else           gate_in = (r < 250) ? ~gate_in : gate_in;
            load_stb = (r >= 990);
            load_val = ($urandom % 2) ? (16'hFFF0 | 16'($urandom % 16)) : 16'($urandom);
            clr_edge = ($urandom % 40) == 0;
            clr_ovf  = ($urandom % 40) == 0;
            step(1);
        end
        load_stb = 0; clr_edge = 0; clr_ovf = 0;
        step(2);
        finish_run();
    end

endmodule